// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to eight peripheral interrupt sources onto a single active-low processor request line. A request edge on a source latches a pending bit in an 8-bit status register. An 8-bit enable register masks the pending bits, and the masked set drives the request line. Both registers sit on a simple memory-mapped bus.

On top of the plain mask-and-combine function, the block tracks the priority level of the handler now running. Source bit i has level i+1, and an idle level 0 lies below every source. A request is offered to the processor only when its level is strictly above the level in service. When the processor acknowledges, the block takes the highest pending enabled source and pushes the interrupted level onto a last-in first-out stack. An end-of-service strobe pops the stack. This lets handlers nest safely, with the most urgent one always on top.

The controller is a two-state machine: IDLE (no handler active, level 0) and SERVE (at least one handler active). It has four named transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| TAKE | IDLE | SERVE | Acknowledge accepted |
| NEST | SERVE | SERVE | Acknowledge accepted |
| UNWIND | SERVE | SERVE | End-of-service pops a non-idle level |
| RETIRE | SERVE | IDLE | End-of-service pops level 0 |

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0, the current level is 0, `irq_n` is 1, `vec_valid` is 0 and `stk_ovf` is 0.
- R2: The status register is at address 0x10000018 and the enable register at 0x1000001C. Both are 8 bits, with bit i belonging to `src_req[i]`. A write to the enable address loads it. A read from any other address returns 0.
- R3: Bit 3 is reserved. It always reads 0 in both registers and is not changed by writes or by `src_req[3]`.
- R4: A status bit is set in the cycle after its source goes from 0 to 1. A source held high sets it only once. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new edge in the same cycle as a clearing write leaves the bit set.
- R5: `irq_n` is 0 exactly when some bit i is both pending and enabled and its level i+1 is strictly greater than the current level.
- R6: `vec_valid` is 1 when any pending bit is also enabled. `vec_id` then gives the highest such bit index, and it is 0 when `vec_valid` is 0.
- R7: `ack` while `irq_n` is 0 (and `eos` is 0) pushes the current level onto the stack. The current level then becomes `vec_id`+1 (TAKE from IDLE, NEST from SERVE).
- R8: `ack` while `irq_n` is 1 leaves the current level and the stack unchanged. `ack` does not clear any status bit.
- R9: `eos` in SERVE pops the top level into the current level: UNWIND, or RETIRE when the popped level is 0. `eos` in IDLE has no effect. When `eos` and `ack` come in the same cycle, `eos` wins and `ack` is ignored.
- R10: A push while the stack already holds STACK_DEPTH entries discards the pushed level but still updates the current level. It sets `stk_ovf`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| src_req | input | 8 | Peripheral request inputs, edge sensitive |
| ack | input | 1 | Processor acknowledge strobe |
| eos | input | 1 | End-of-service strobe |
| vec_valid | output | 1 | Some enabled source is pending |
| vec_id | output | 3 | Highest pending enabled source index |
| cur_level | output | 4 | Priority level in service (0 = idle) |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| irq_n | output | 1 | Active-low processor request |

## Verification
The properties assume that `ack` and `eos` are single-cycle strobes issued by a processor. They also assume that a level popped by end of service was pushed earlier by a strictly lower handler, so every pop lowers the level. The stimulus changes sources, strobes and bus writes only at the falling clock edge, and never holds `ack` or `eos` for more than one cycle. The overflow case is reached with a second, shallower instance driven by the same inputs, so the default-depth instance never overflows while the shallow one does.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } svc_state_t;

endpackage

// File: rtl/pic_src_regs.sv
module pic_src_regs #(
    parameter int          NSRC      = 8,
    parameter int          ADDR_W    = 32,
    parameter int          RSVD_BIT  = 3,
    parameter logic [31:0] STAT_ADDR = 32'h1000_0018,
    parameter logic [31:0] EN_ADDR   = 32'h1000_001C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    input  logic [NSRC-1:0]   src_req,
    output logic [NSRC-1:0]   status,
    output logic [NSRC-1:0]   enable,
    output logic [NSRC-1:0]   rdata
);
    localparam logic [NSRC-1:0] KEEP = ~(NSRC'(1) << RSVD_BIT);

    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr;
    logic            hit_stat;
    logic            hit_en;

    assign hit_stat = (bus_addr == STAT_ADDR[ADDR_W-1:0]);
    assign hit_en   = (bus_addr == EN_ADDR[ADDR_W-1:0]);
    assign rise     = src_req & ~src_q;
    assign clr      = (bus_wr && hit_stat) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            status <= '0;
            enable <= '0;
        end else begin
            src_q  <= src_req;
            status <= ((status & ~clr) | rise) & KEEP;
            if (bus_wr && hit_en)
                enable <= bus_wdata & KEEP;
        end
    end

    always_comb begin
        if (hit_stat)
            rdata = status;
        else if (hit_en)
            rdata = enable;
        else
            rdata = '0;
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC),
    parameter int LVL_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]  pending,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [LVL_W-1:0] level
);
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        level = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pending[i]) begin
                any   = 1'b1;
                idx   = IDX_W'(i);
                level = LVL_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/pic_lvl_stack.sv
module pic_lvl_stack #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] top,
    output logic             ovf
);
    logic [LVL_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] cnt;
    logic             full;

    assign full = (cnt == PTR_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= '0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                for (int i = 0; i < DEPTH; i++)
                    if (cnt == PTR_W'(i))
                        slot[i] <= din;
            end
        end else if (pop && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt == PTR_W'(i + 1))
                top = slot[i];
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int          NSRC        = 8,
    parameter int          ADDR_W      = 32,
    parameter int          RSVD_BIT    = 3,
    parameter int          STACK_DEPTH = 8,
    parameter logic [31:0] STAT_ADDR   = 32'h1000_0018,
    parameter logic [31:0] EN_ADDR     = 32'h1000_001C,
    parameter int          IDX_W       = $clog2(NSRC),
    parameter int          LVL_W       = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_req,
    input  logic              ack,
    input  logic              eos,
    output logic              vec_valid,
    output logic [IDX_W-1:0]  vec_id,
    output logic [LVL_W-1:0]  cur_level,
    output logic              stk_ovf,
    output logic              irq_n
);
    svc_state_t       state_q, state_d;
    logic [NSRC-1:0]  stat_w, en_w;
    logic             any_w;
    logic [IDX_W-1:0] idx_w;
    logic [LVL_W-1:0] best_lvl, lvl_q, top_w;
    logic             irq_req, take, retire, in_service;

    pic_src_regs #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .RSVD_BIT(RSVD_BIT),
        .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .src_req(src_req),
        .status(stat_w), .enable(en_w), .rdata(bus_rdata)
    );

    pic_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_prio (
        .pending(stat_w & en_w), .any(any_w), .idx(idx_w), .level(best_lvl)
    );

    pic_lvl_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .pop(retire),
        .din(lvl_q), .top(top_w), .ovf(stk_ovf)
    );

    assign irq_req    = any_w && (best_lvl > lvl_q);
    assign take       = ack && !eos && irq_req;
    assign retire     = eos && (state_q == ST_SERVE);
    assign in_service = (state_q == ST_SERVE);

    // Next-state logic: TAKE, NEST, UNWIND, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_SERVE;
            ST_SERVE: if (retire && top_w == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                lvl_q <= best_lvl;
            else if (retire)
                lvl_q <= top_w;
        end
    end

    // Outputs
    always_comb begin
        irq_n     = ~irq_req;
        vec_valid = any_w;
        vec_id    = idx_w;
        cur_level = lvl_q;
    end
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
    parameter int NSRC     = 8,
    parameter int LVL_W    = 4,
    parameter int RSVD_BIT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             eos,
    input logic             irq_n,
    input logic             in_service,
    input logic [LVL_W-1:0] cur_level,
    input logic             stk_ovf,
    input logic [NSRC-1:0]  status,
    input logic [NSRC-1:0]  enable
);
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !status[RSVD_BIT] && !enable[RSVD_BIT]);

    p_irq_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((status & enable) != '0));

    p_take_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eos && !irq_n) |=> (cur_level > $past(cur_level)));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_service |-> (cur_level == '0));

    p_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eos && irq_n) |=> $stable(cur_level));

    p_unwind_lowers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && in_service) |=> (cur_level < $past(cur_level)));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);
endmodule

bind nest_irq_ctrl nest_irq_chk #(
    .NSRC(NSRC), .LVL_W(LVL_W), .RSVD_BIT(RSVD_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eos(eos), .irq_n(irq_n),
    .in_service(in_service), .cur_level(cur_level), .stk_ovf(stk_ovf),
    .status(stat_w), .enable(en_w)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
    localparam logic [31:0] A_STAT = 32'h1000_0018;
    localparam logic [31:0] A_EN   = 32'h1000_001C;
    // fields: [27:20] enable, [19:12] source, [11:4] status, [3] irq_n, [2:0] vec_id
    localparam logic [27:0] TBL [6] = '{
        28'hFF0101_0, 28'hFF0C04_2, 28'h00A0A0_8,
        28'h20A0A0_5, 28'h080800_8, 28'h7FC2C2_6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  src_req = '0;
    logic        ack = 1'b0;
    logic        eos = 1'b0;
    logic [7:0]  rdata0, rdata1;
    logic        vv0, vv1, ovf0, ovf1, irqn0, irqn1;
    logic [2:0]  vid0, vid1;
    logic [3:0]  lvl0, lvl1;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .src_req(src_req),
        .ack(ack), .eos(eos), .vec_valid(vv0), .vec_id(vid0),
        .cur_level(lvl0), .stk_ovf(ovf0), .irq_n(irqn0)
    );

    nest_irq_ctrl #(.STACK_DEPTH(2)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .src_req(src_req),
        .ack(ack), .eos(eos), .vec_valid(vv1), .vec_id(vid1),
        .cur_level(lvl1), .stk_ovf(ovf1), .irq_n(irqn1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = rdata0;
    endtask

    task automatic strobe(input logic a, input logic e);
        ack = a; eos = e;
        cyc();
        ack = 1'b0; eos = 1'b0;
    endtask

    task automatic cleanup();
        src_req = '0;
        cyc();
        wr(A_STAT, 8'hFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        rd(A_STAT, r); chk("R1 status", r, 0);
        rd(A_EN, r);   chk("R1 enable", r, 0);
        chk("R1 irq_n", irqn0, 1);
        chk("R1 level", lvl0, 0);
        chk("R1 vec_valid", vv0, 0);
        chk("R1 ovf", ovf0, 0);

        // R2 / R3 addressing and reserved bit
        wr(A_EN, 8'hFF);
        rd(A_EN, r); chk("R2 R3 enable readback", r, 8'hF7);
        rd(32'h1000_0014, r); chk("R2 unmapped read", r, 0);

        // Vector table walk: R3 R4 R5 R6
        for (int k = 0; k < 6; k++) begin
            src_req = '0;
            cyc();
            wr(A_STAT, 8'hFF);
            wr(A_EN, TBL[k][27:20]);
            src_req = TBL[k][19:12];
            cyc();
            rd(A_STAT, r); chk("R4 R3 table status", r, TBL[k][11:4]);
            chk("R5 table irq_n", irqn0, TBL[k][3]);
            chk("R6 table vec_valid", vv0, !TBL[k][3]);
            chk("R6 table vec_id", vid0, TBL[k][3] ? 3'd0 : TBL[k][2:0]);
        end

        // R4 edge/clear behaviour
        cleanup();
        src_req = 8'h01; cyc();
        wr(A_STAT, 8'h01); cyc();
        rd(A_STAT, r); chk("R4 held level sets once", r, 0);
        src_req = 8'h41; cyc();
        wr(A_STAT, 8'h00);
        rd(A_STAT, r); chk("R4 write 0 no effect", r, 8'h40);
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'hC1; src_req = 8'hC1;
        cyc();
        bus_wr = 1'b0;
        rd(A_STAT, r); chk("R4 edge beats clear", r, 8'h80);

        // Nesting: R5 R7 R8 R9
        cleanup();
        wr(A_EN, 8'hFF);
        src_req = 8'h02; cyc();
        chk("R5 irq for bit1", irqn0, 0);
        strobe(1'b1, 1'b0);
        chk("R7 take level", lvl0, 2);
        chk("R5 no irq at same level", irqn0, 1);
        rd(A_STAT, r); chk("R8 ack keeps status", r, 8'h02);
        strobe(1'b1, 1'b0);
        chk("R8 ignored ack", lvl0, 2);
        src_req = 8'h22; cyc();
        chk("R5 higher level irq", irqn0, 0);
        chk("R6 vec 5", vid0, 5);
        strobe(1'b1, 1'b0);
        chk("R7 nest level", lvl0, 6);
        src_req = 8'h32; cyc();
        chk("R5 lower request held off", irqn0, 1);
        strobe(1'b0, 1'b1);
        chk("R9 unwind", lvl0, 2);
        strobe(1'b0, 1'b1);
        chk("R9 retire", lvl0, 0);
        strobe(1'b0, 1'b1);
        chk("R9 eos in idle", lvl0, 0);
        strobe(1'b1, 1'b1);
        chk("R9 eos blocks ack", lvl0, 0);

        // R10 overflow with shallow instance
        cleanup();
        src_req = 8'h01; cyc(); strobe(1'b1, 1'b0);
        src_req = 8'h05; cyc(); strobe(1'b1, 1'b0);
        src_req = 8'h25; cyc(); strobe(1'b1, 1'b0);
        chk("R10 deep level", lvl0, 6);
        chk("R10 shallow level", lvl1, 6);
        chk("R10 deep no ovf", ovf0, 0);
        chk("R10 shallow ovf", ovf1, 1);
        strobe(1'b0, 1'b1);
        chk("R10 deep pop", lvl0, 3);
        chk("R10 shallow pop skips lost", lvl1, 1);
        strobe(1'b0, 1'b1);
        chk("R10 shallow retire", lvl1, 0);
        chk("R10 ovf sticky", ovf1, 1);
        chk("R9 deep pop second", lvl0, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule